// File: doc/BRIEF.md
# Lock-Armed Watchdog with Reset-Out Pulse

This block is a hardware watchdog that sits idle from power-up and only comes to life once software writes a two-byte key sequence into its restart register. Once armed, a counter advances on every machine-cycle tick. Software has no way to stop it again. The only way to keep the chip out of reset is to repeat the same two-byte key sequence before the counter fills up.

When the counter reaches its all-ones value, the block raises an internal reset request and drops back to its power-up state, disarmed with the counter cleared. It then drives the reset pin high for a fixed number of oscillator clocks. The clock input is the oscillator clock. A separate one-clock strobe marks each machine cycle, which normally comes once every twelve oscillator clocks. The counter keeps running while the processor idles. It freezes while the power-down flag is high.

Top module: `lockarm_wdt`

## Requirements
- R1: After reset the watchdog is disarmed, and neither `rst_req` nor `rst_pin` asserts, however many ticks arrive, until it is armed.
- R2: A write of 0x1E followed by a write of 0xE1 (the very next write) arms the watchdog and clears its 14-bit counter to 0 in the clock that accepts the 0xE1 write.
- R3: The same two-write sequence while armed restarts the counter from 0. With a tick on every clock, `rst_req` rises exactly 16383 clocks after the clock that accepted the 0xE1 write.
- R4: While armed, the counter advances by one only on clocks where `mc_tick` is high. A clock without a tick delays the trip by one clock.
- R5: `rst_req` asserts in the same cycle that the counter holds 0x3FFF. At the next edge the watchdog returns to the disarmed power-up state, so no further reset occurs unless it is armed again.
- R6: `rst_pin` goes high at the edge after the trip and stays high for exactly 96 clocks. `rst_req` stays high throughout and drops together with `rst_pin`.
- R7: Any write other than 0xE1 that directly follows 0xE1's partner write 0x1E cancels the pending sequence. A lone 0xE1 has no effect. No written value disarms an armed watchdog.
- R8: A 0x1E written while a sequence is pending starts the sequence over, so 0x1E, 0x1E, 0xE1 is a valid restart.
- R9: With the default setting, a high `idle` does not slow or stop the counter.
- R10: While `pdown` is high, the counter holds its value and no trip occurs. Each clock spent in power-down delays the trip by one clock.
- R11: Writes that arrive while `rst_pin` is high are ignored, including a full key sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low power-on reset |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| wr_en | input | 1 | Write strobe to the restart register |
| wr_data | input | 8 | Byte written to the restart register |
| idle | input | 1 | Processor idle flag |
| pdown | input | 1 | Power-down flag |
| rst_req | output | 1 | Internal chip reset request |
| rst_pin | output | 1 | Reset pin drive, high during the reset-out pulse |

## Verification
The assertions assume three things. `wr_en` and `mc_tick` are synchronous single-clock strobes. A write never falls in the same clock as the counter reaching 0x3FFF. `pdown` changes only between clocks. The stimulus meets these by driving every input on the falling clock edge. Each key byte gets its own one-clock strobe. The power-down and tick-gap windows are placed thousands of cycles away from any expected trip. Expected trip cycles are worked out from the clock that accepted the last key write, plus the count of clocks lost to tick gaps and power-down.

// File: rtl/lockarm_wdt_pkg.sv
package lockarm_wdt_pkg;
   // State of the two-write key detector
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_HALF = 1'b1
   } seq_e;

   localparam logic [7:0] DEF_KEY_OPEN  = 8'h1E;
   localparam logic [7:0] DEF_KEY_CLOSE = 8'hE1;
endpackage

// File: rtl/lockarm_seq.sv
module lockarm_seq
   import lockarm_wdt_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter logic [DATA_W-1:0] KEY_OPEN  = DATA_W'(DEF_KEY_OPEN),
   parameter logic [DATA_W-1:0] KEY_CLOSE = DATA_W'(DEF_KEY_CLOSE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              block,
   input  logic              clear,
   output logic              restart
);
   seq_e st_q;
   logic take;

   assign take    = wr_en && !block;
   assign restart = take && (st_q == SEQ_HALF) && (wr_data == KEY_CLOSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= SEQ_IDLE;
      else if (clear)
         st_q <= SEQ_IDLE;
      else if (take)
         st_q <= (wr_data == KEY_OPEN) ? SEQ_HALF : SEQ_IDLE;
   end
endmodule

// File: rtl/lockarm_cnt.sv
module lockarm_cnt #(
   parameter int CNT_W       = 14,
   parameter bit IDLE_COUNTS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             mc_tick,
   input  logic             idle,
   input  logic             pdown,
   output logic             armed,
   output logic [CNT_W-1:0] cnt,
   output logic             trip
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic stall;
   logic step;

   assign stall = pdown || (!IDLE_COUNTS && idle);
   assign step  = armed && mc_tick && !stall;
   assign trip  = armed && (cnt == CNT_MAX) && !pdown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (trip) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (restart) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (step) begin
         cnt   <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/lockarm_pulse.sv
module lockarm_pulse #(
   parameter int PULSE_LEN = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   output logic active
);
   localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN + 1) : 1;

   generate
      if (PULSE_LEN == 1) begin : g_single
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= trip;
         end
         assign active = hit_q;
      end else begin : g_timer
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (trip)
               left_q <= PW'(PULSE_LEN);
            else if (left_q != '0)
               left_q <= left_q - PW'(1);
         end
         assign active = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/lockarm_wdt.sv
module lockarm_wdt
   import lockarm_wdt_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                CNT_W       = 14,
   parameter int                PULSE_LEN   = 96,
   parameter bit                IDLE_COUNTS = 1'b1,
   parameter logic [DATA_W-1:0] KEY_OPEN    = DATA_W'(DEF_KEY_OPEN),
   parameter logic [DATA_W-1:0] KEY_CLOSE   = DATA_W'(DEF_KEY_CLOSE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              idle,
   input  logic              pdown,
   output logic              rst_req,
   output logic              rst_pin
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("lockarm_wdt: CNT_W must be at least 2");
      end
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("lockarm_wdt: PULSE_LEN must be at least 1");
      end
      if (KEY_OPEN == KEY_CLOSE) begin : g_bad_key
         $error("lockarm_wdt: the two key bytes must differ");
      end
   endgenerate

   logic             restart;
   logic             armed;
   logic             trip;
   logic             pulse_on;
   logic [CNT_W-1:0] cnt_q;

   lockarm_seq #(
      .DATA_W   (DATA_W),
      .KEY_OPEN (KEY_OPEN),
      .KEY_CLOSE(KEY_CLOSE)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .block  (pulse_on),
      .clear  (trip),
      .restart(restart)
   );

   lockarm_cnt #(
      .CNT_W      (CNT_W),
      .IDLE_COUNTS(IDLE_COUNTS)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .mc_tick(mc_tick),
      .idle   (idle),
      .pdown  (pdown),
      .armed  (armed),
      .cnt    (cnt_q),
      .trip   (trip)
   );

   lockarm_pulse #(
      .PULSE_LEN(PULSE_LEN)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .trip  (trip),
      .active(pulse_on)
   );

   assign rst_req = trip || pulse_on;
   assign rst_pin = pulse_on;
endmodule

// File: rtl/lockarm_wdt_chk.sv
module lockarm_wdt_chk #(
   parameter int CNT_W     = 14,
   parameter int PULSE_LEN = 96
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mc_tick,
   input logic             pdown,
   input logic             restart,
   input logic             armed,
   input logic             trip,
   input logic [CNT_W-1:0] cnt,
   input logic             rst_req,
   input logic             rst_pin
);
   int hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len <= 0;
      else if (rst_pin) hi_len <= hi_len + 1;
      else              hi_len <= 0;
   end

   // R1: no reset request while disarmed and outside a pulse
   p_quiet_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !rst_pin) |-> !rst_req);

   // R4: no tick, no step
   p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !mc_tick && !restart && !trip) |=> $stable(cnt));

   // R4: a tick adds exactly one
   p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mc_tick && !pdown && !restart && !trip) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R5: a trip disarms and starts the pin pulse
   p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> (!armed && rst_pin));

   // R6: the pin only rises after a trip
   p_pin_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_pin) |-> $past(trip));

   // R6: pulse length
   p_pin_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pin) |-> (hi_len == PULSE_LEN));

   // R10: power-down freezes the count
   p_pdown_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pdown && !restart) |=> $stable(cnt));
endmodule

bind lockarm_wdt lockarm_wdt_chk #(
   .CNT_W    (CNT_W),
   .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mc_tick(mc_tick),
   .pdown  (pdown),
   .restart(restart),
   .armed  (armed),
   .trip   (trip),
   .cnt    (cnt_q),
   .rst_req(rst_req),
   .rst_pin(rst_pin)
);

// File: tb/test_lockarm_wdt.sv
`timescale 1ns/1ps
module test_lockarm_wdt;
   localparam int MAXC = 16383;
   localparam int PLEN = 96;
   localparam int WD_LIMIT = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       idle = 1'b0;
   logic       pdown = 1'b0;
   logic       rst_req;
   logic       rst_pin;

   always #2 clk = ~clk;

   lockarm_wdt i_lockarm_wdt (
      .clk    (clk),
      .rst_n  (rst_n),
      .mc_tick(mc_tick),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .idle   (idle),
      .pdown  (pdown),
      .rst_req(rst_req),
      .rst_pin(rst_pin)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      bit    pin;
      bit    val;
      string tag;
   } exp_t;

   exp_t q[$];
   exp_t mon_e;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   task automatic expect_at(input int at, input bit pin, input bit val, input string tag);
      exp_t e;
      e.at = at; e.pin = pin; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   // Monitor: pops expectations whose cycle has come
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at <= cyc) begin
         logic act;
         mon_e = q.pop_front();
         act = mon_e.pin ? rst_pin : rst_req;
         n_cmp++;
         if (mon_e.at != cyc) begin
            n_bad++;
            $display("FAIL %s: check for cycle %0d missed at cycle %0d", mon_e.tag, mon_e.at, cyc);
         end else if (act !== mon_e.val) begin
            n_bad++;
            $display("FAIL %s: %s at cycle %0d actual %b expected %b",
                     mon_e.tag, mon_e.pin ? "rst_pin" : "rst_req", cyc, act, mon_e.val);
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > WD_LIMIT && !done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung at cycle %0d, expected end before %0d", cyc, WD_LIMIT);
         summary();
      end
   end

   task automatic wr(input logic [7:0] b, output int cap);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = b;
      cap = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic arm(output int cap);
      int c0;
      wr(8'h1E, c0);
      wr(8'hE1, cap);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   initial begin
      int a, b, t, base, dummy;
      repeat (3) @(negedge clk);
      expect_at(cyc + 1, 1'b0, 1'b0, "R1 reset req");
      expect_at(cyc + 1, 1'b1, 1'b0, "R1 reset pin");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mc_tick = 1'b1;

      // R1: ticks alone never trip
      base = cyc;
      expect_at(base + 5000, 1'b0, 1'b0, "R1");
      expect_at(base + 17000, 1'b0, 1'b0, "R1");
      expect_at(base + 17000, 1'b1, 1'b0, "R1");
      wait_until(base + 17001);

      // R2 R5 R6: arm and let it expire
      arm(a);
      t = a + MAXC;
      expect_at(t - 1, 1'b0, 1'b0, "R2 R3");
      expect_at(t, 1'b0, 1'b1, "R2 R5");
      expect_at(t, 1'b1, 1'b0, "R6");
      expect_at(t + 1, 1'b1, 1'b1, "R6");
      expect_at(t + 1, 1'b0, 1'b1, "R6");
      expect_at(t + PLEN, 1'b1, 1'b1, "R6");
      expect_at(t + PLEN + 1, 1'b1, 1'b0, "R6");
      expect_at(t + PLEN + 1, 1'b0, 1'b0, "R6");
      wait_until(t + 10);
      // R11: key sequence during the pulse is ignored
      wr(8'h1E, dummy);
      wr(8'hE1, dummy);
      wait_until(t + PLEN + 2);

      // R5 R11: disarmed after trip, no further reset
      base = cyc;
      expect_at(base + 16600, 1'b0, 1'b0, "R5 R11");
      expect_at(base + 16600, 1'b1, 1'b0, "R5 R11");
      wait_until(base + 16601);

      // R7: broken or stray writes do not restart or disarm
      arm(a);
      t = a + MAXC;
      expect_at(t - 1, 1'b0, 1'b0, "R7");
      expect_at(t, 1'b0, 1'b1, "R7");
      expect_at(t + 1, 1'b1, 1'b1, "R7");
      wait_until(a + 3000);
      wr(8'h1E, dummy);
      wr(8'h55, dummy);
      wr(8'hE1, dummy);
      wr(8'hE1, dummy);
      wr(8'h00, dummy);
      wait_until(t + PLEN + 5);

      // R3 R8: restart via 1E,1E,E1
      arm(a);
      expect_at(a + MAXC, 1'b0, 1'b0, "R3 R8");
      wait_until(a + 5000);
      wr(8'h1E, dummy);
      wr(8'h1E, dummy);
      wr(8'hE1, b);
      expect_at(b + MAXC - 1, 1'b0, 1'b0, "R3 R8");
      expect_at(b + MAXC, 1'b0, 1'b1, "R3 R8");
      wait_until(b + MAXC + PLEN + 5);

      // R4 R9 R10: idle keeps counting, power-down and tick gaps delay
      idle = 1'b1;
      arm(a);
      t = a + MAXC + 700 + 300;
      expect_at(t - 1, 1'b0, 1'b0, "R4 R9 R10");
      expect_at(t, 1'b0, 1'b1, "R4 R9 R10");
      expect_at(t + 1, 1'b1, 1'b1, "R9 R10");
      wait_until(a + 2000);
      pdown = 1'b1;
      repeat (700) @(negedge clk);
      pdown = 1'b0;
      wait_until(a + 4000);
      mc_tick = 1'b0;
      repeat (300) @(negedge clk);
      mc_tick = 1'b1;
      wait_until(t + PLEN + 5);
      idle = 1'b0;

      if (q.size() != 0) begin
         n_cmp++;
         n_bad++;
         $display("FAIL queue: %0d checks left unconsumed, expected 0", q.size());
      end
      done = 1'b1;
      summary();
   end
endmodule